// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the register-transfer datapath of a small 32-bit load/store processor. It runs register-register arithmetic (add, subtract, and, or, set-on-less-than), word load, word store, branch-if-equal and absolute jump. Each instruction takes three to five clock cycles. One memory port serves both instruction fetch and data access. One ALU does all arithmetic, including the PC increment, the branch target sum and the address sum. Every functional-unit output is captured in a register so that the next cycle can use it: program counter, instruction register, memory data register, the two operand latches and the ALU result register. A 32-entry register file and all source multiplexers sit inside the block.

The block has no sequencing of its own. An external control unit drives every multiplexer select and write enable in each cycle. The datapath returns the opcode field, the function field and the ALU zero flag to that unit. The memory sits outside the block and is read combinationally. Its write strobe comes from the control unit. The datapath supplies the address and the store data. The control and memory pins are plain level signals with no handshake, because every access completes in the cycle in which the control unit issues it.

Top module: `mcd_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared at that edge: the program counter, the instruction register, the operand latches, the memory data register, the ALU result register and all register-file entries. After reset, `mem_addr` is 0 when `iord` is 0, and `opcode` and `funct` are both 0.
- R2: The instruction register captures `mem_rdata` at a clock edge only when `ir_write` is 1. Otherwise it holds its value. `opcode` shows instruction bits 31:26 and `funct` shows bits 5:0.
- R3: The program counter loads the selected next-PC value at a clock edge when `pc_write` is 1, or when `pc_write_cond` is 1 and `zero` is 1. Otherwise it holds its value. Within one fetch cycle, the instruction register load and the PC-plus-4 update take effect at the same edge.
- R4: `mem_addr` equals the program counter when `iord` is 0 and the ALU result register when `iord` is 1. `mem_wdata` always equals operand latch B.
- R5: At every clock edge, operand latch A takes the register named by instruction bits 25:21 and latch B takes the register named by bits 20:16.
- R6: ALU input A is the program counter when `alu_src_a` is 0 and latch A when it is 1. ALU input B is chosen by `alu_src_b`: 0 selects latch B, 1 selects the constant 4, 2 selects the sign-extended bits 15:0, and 3 selects that value shifted left by 2.
- R7: `alu_op` encodes the operation: 3'b000 and, 3'b001 or, 3'b010 add, 3'b110 subtract, 3'b111 signed set-on-less-than (result 1 or 0). `zero` is 1 exactly when the ALU result is 0. The ALU result register captures the result at every edge.
- R8: `pc_source` selects the next-PC value: 0 the live ALU result, 1 the ALU result register, 2 the jump target made of PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R9: When `reg_write` is 1, the register file is written at the clock edge. The destination is bits 20:16 when `reg_dst` is 0 and bits 15:11 when `reg_dst` is 1. The data is the ALU result register when `mem_to_reg` is 0 and the memory data register when it is 1. The memory data register captures `mem_rdata` at every edge.
- R10: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Store data (operand latch B) |
| ir_write | input | 1 | Instruction register load enable |
| pc_write | input | 1 | Unconditional PC load enable |
| pc_write_cond | input | 1 | PC load enable qualified by `zero` |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| reg_write | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination field select: 0 bits 20:16, 1 bits 15:11 |
| mem_to_reg | input | 1 | Write-back data select: 0 ALU result register, 1 memory data register |
| alu_src_a | input | 1 | ALU input A select |
| alu_src_b | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| pc_source | input | 2 | Next-PC source select |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result equals zero |

## Verification
Two cases in this block update dependent registers at the same clock edge. In the fetch cycle, the instruction register captures the word at the old PC while the PC takes PC+4 from the ALU. The bench judges this after the edge: `opcode`/`funct` must match the word that was at the old address, and `mem_addr` must show the advanced PC. In the branch execute cycle, the PC loads the target held in the ALU result register at the same edge where that register is overwritten by the A−B comparison. The bench provokes this with a taken and an untaken compare, then reads the resulting PC through `mem_addr`. A hold cycle with `pc_write_cond` high and a nonzero ALU result, plus `ir_write` low, checks that neither register moves.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'd0,
    SRCB_FOUR = 2'd1,
    SRCB_IMM  = 2'd2,
    SRCB_IMM4 = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_ALU    = 2'd0,
    PCS_ALUREG = 2'd1,
    PCS_JUMP   = 2'd2
  } pcsrc_e;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;

  assign diff = a - b;

  always_comb begin
    case (alu_op_e'(op))
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
  import mcd_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                          regs[i] <= '0;
        else if (we && wa == AW'(i))      regs[i] <= wd;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
  import mcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        ir_write,
  input  logic        pc_write,
  input  logic        pc_write_cond,
  input  logic        iord,
  input  logic        reg_write,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  input  logic        alu_src_a,
  input  logic [1:0]  alu_src_b,
  input  logic [2:0]  alu_op,
  input  logic [1:0]  pc_source,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [XLEN-1:0] opnd_a, opnd_b, alu_y, pc_next;
  logic [XLEN-1:0] imm_sx, imm_sx4, jump_tgt;
  logic [RIDX_W-1:0] rs_sel, rt_sel, rd_sel, wr_sel;
  logic pc_load;

  // instruction fields
  assign rs_sel   = ir_q[25:21];
  assign rt_sel   = ir_q[20:16];
  assign rd_sel   = ir_q[15:11];
  assign opcode   = ir_q[31:26];
  assign funct    = ir_q[5:0];
  assign imm_sx   = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_sx4  = {imm_sx[XLEN-3:0], 2'b00};
  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  // register file with write-back selection
  assign wr_sel = reg_dst ? rd_sel : rt_sel;
  assign rf_wd  = mem_to_reg ? mdr_q : aluout_q;

  mcd_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (rs_sel),
    .ra2 (rt_sel),
    .we  (reg_write),
    .wa  (wr_sel),
    .wd  (rf_wd),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2)
  );

  // ALU operand selection
  assign opnd_a = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (srcb_e'(alu_src_b))
      SRCB_REG:  opnd_b = b_q;
      SRCB_FOUR: opnd_b = XLEN'(4);
      SRCB_IMM:  opnd_b = imm_sx;
      default:   opnd_b = imm_sx4;
    endcase
  end

  mcd_alu #(.W(XLEN)) u_alu (
    .a    (opnd_a),
    .b    (opnd_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (zero)
  );

  // next PC
  always_comb begin
    case (pcsrc_e'(pc_source))
      PCS_ALUREG: pc_next = aluout_q;
      PCS_JUMP:   pc_next = jump_tgt;
      default:    pc_next = alu_y;
    endcase
  end

  assign pc_load = pc_write | (pc_write_cond & zero);

  // state registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_load)  pc_q <= pc_next;
      if (ir_write) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
    end
  end

  // memory side
  assign mem_addr  = iord ? aluout_q : pc_q;
  assign mem_wdata = b_q;
endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk (
  input logic        clk,
  input logic        rst,
  input logic        ir_write,
  input logic        pc_write,
  input logic        pc_write_cond,
  input logic        zero,
  input logic [31:0] mem_rdata,
  input logic [31:0] ir_q,
  input logic [31:0] pc_q,
  input logic [31:0] pc_next,
  input logic [4:0]  rs_sel,
  input logic [31:0] rf_rd1
);
  AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc_q == 32'd0)); // R1

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ir_write |=> (ir_q == $past(mem_rdata))); // R2

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_write |=> $stable(ir_q)); // R2

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (pc_write || (pc_write_cond && zero)) |=> (pc_q == $past(pc_next))); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && !(pc_write_cond && zero)) |=> $stable(pc_q)); // R3

  AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
    (rs_sel == 5'd0) |-> (rf_rd1 == 32'd0)); // R10
endmodule

bind mcd_datapath mcd_datapath_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ir_write      (ir_write),
  .pc_write      (pc_write),
  .pc_write_cond (pc_write_cond),
  .zero          (zero),
  .mem_rdata     (mem_rdata),
  .ir_q          (ir_q),
  .pc_q          (pc_q),
  .pc_next       (pc_next),
  .rs_sel        (rs_sel),
  .rf_rd1        (rf_rd1)
);

// File: tb/tb_mcd_datapath.sv
module tb_mcd_datapath;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        ir_write, pc_write, pc_write_cond, iord;
  logic        reg_write, reg_dst, mem_to_reg, alu_src_a;
  logic [1:0]  alu_src_b, pc_source;
  logic [2:0]  alu_op;
  logic [5:0]  opcode, funct;
  logic        zero;

  logic [31:0] mem [64];
  logic [31:0] pc_exp;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                         OP_SUB = 3'b110, OP_SLT = 3'b111;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:2]];

  mcd_datapath dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .iord(iord), .reg_write(reg_write),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_source(pc_source),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ir_write = 0; pc_write = 0; pc_write_cond = 0; iord = 0;
    reg_write = 0; reg_dst = 0; mem_to_reg = 0; alu_src_a = 0;
    alu_src_b = 2'd0; alu_op = OP_ADD; pc_source = 2'd0;
  endtask

  // fetch: IR and PC+4 at one edge (R2, R3)
  task automatic fetch(input logic [31:0] instr);
    mem[pc_exp[7:2]] = instr;
    idle();
    ir_write = 1; pc_write = 1; alu_src_b = 2'd1; alu_op = OP_ADD;
    #1 check("R4 fetch address is PC", mem_addr, pc_exp);
    tick();
    pc_exp = pc_exp + 32'd4;
    idle();
    #1;
    check("R3 PC advanced by 4 in fetch", mem_addr, pc_exp);
    check("R2 opcode from fetched word", {26'd0, opcode}, {26'd0, instr[31:26]});
    check("R2 funct from fetched word", {26'd0, funct}, {26'd0, instr[5:0]});
  endtask

  task automatic decode();
    idle();
    alu_src_b = 2'd3; alu_op = OP_ADD;
    tick();
  endtask

  task automatic addr_exec();
    idle();
    alu_src_a = 1; alu_src_b = 2'd2; alu_op = OP_ADD;
    tick();
  endtask

  task automatic t_load(input logic [4:0] rt, input logic [4:0] rs,
                        input logic [15:0] imm, input logic [31:0] exp_addr);
    fetch({6'h23, rs, rt, imm});
    decode();
    addr_exec();
    idle(); iord = 1;
    #1 check("R6 load address A+sext(imm)", mem_addr, exp_addr);
    tick();
    idle(); reg_write = 1; reg_dst = 0; mem_to_reg = 1;
    tick();
    idle();
  endtask

  task automatic t_store(input logic [4:0] rt, input logic [4:0] rs,
                         input logic [15:0] imm, input logic [31:0] exp_addr,
                         input logic [31:0] exp_data, input string tag);
    fetch({6'h2b, rs, rt, imm});
    decode();
    addr_exec();
    idle(); iord = 1;
    #1;
    check("R4 store address from ALU result register", mem_addr, exp_addr);
    check(tag, mem_wdata, exp_data);
    mem[mem_addr[7:2]] = mem_wdata;
    tick();
    idle();
  endtask

  task automatic t_rtype(input logic [5:0] fn, input logic [4:0] rd,
                         input logic [4:0] rs, input logic [4:0] rt,
                         input logic [2:0] op);
    fetch({6'h00, rs, rt, rd, 5'd0, fn});
    decode();
    idle(); alu_src_a = 1; alu_src_b = 2'd0; alu_op = op;
    tick();
    idle(); reg_write = 1; reg_dst = 1; mem_to_reg = 0;
    tick();
    idle();
  endtask

  task automatic t_beq(input logic [4:0] rs, input logic [4:0] rt,
                       input logic [15:0] off, input bit taken);
    logic [31:0] tgt;
    fetch({6'h04, rs, rt, off});
    tgt = pc_exp + {{14{off[15]}}, off, 2'b00};
    decode();
    idle(); alu_src_a = 1; alu_src_b = 2'd0; alu_op = OP_SUB;
    pc_write_cond = 1; pc_source = 2'd1;
    #1 check("R7 zero flag on compare", {31'd0, zero}, {31'd0, taken});
    tick();
    if (taken) pc_exp = tgt;
    idle();
    #1 check("R8 PC after branch", mem_addr, pc_exp);
  endtask

  task automatic t_jump(input logic [25:0] tgt);
    fetch({6'h02, tgt});
    decode();
    idle(); pc_write = 1; pc_source = 2'd2;
    tick();
    pc_exp = {pc_exp[31:28], tgt, 2'b00};
    idle();
    #1 check("R8 PC after jump", mem_addr, pc_exp);
  endtask

  task automatic t_hold();
    logic [5:0] op_before;
    op_before = opcode;
    idle();
    ir_write = 0; pc_write = 0; pc_write_cond = 1;
    alu_src_a = 0; alu_src_b = 2'd1; alu_op = OP_ADD;
    #1 check("R7 zero low on nonzero sum", {31'd0, zero}, 32'd0);
    tick();
    idle();
    #1;
    check("R2 IR holds without ir_write", {26'd0, opcode}, {26'd0, op_before});
    check("R3 PC holds when condition fails", mem_addr, pc_exp);
  endtask

  task automatic t_reset();
    rst = 1; idle();
    tick(); tick();
    rst = 0;
    #1;
    check("R1 PC reset to 0", mem_addr, 32'd0);
    check("R1 IR reset opcode", {26'd0, opcode}, 32'd0);
    check("R1 IR reset funct", {26'd0, funct}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[48] = 32'd7;
    mem[49] = 32'hFFFF_FFFD;
    mem[50] = 32'h0000_00E0;
    pc_exp = 32'd0;
    idle();
    t_reset();

    t_load(5'd1, 5'd0, 16'h00C0, 32'h0000_00C0);
    t_hold();
    t_load(5'd2, 5'd0, 16'h00C4, 32'h0000_00C4);
    t_load(5'd10, 5'd0, 16'h00C8, 32'h0000_00C8);

    t_rtype(6'h20, 5'd3, 5'd1, 5'd2, OP_ADD);
    t_rtype(6'h22, 5'd4, 5'd1, 5'd2, OP_SUB);
    t_rtype(6'h24, 5'd5, 5'd1, 5'd2, OP_AND);
    t_rtype(6'h25, 5'd6, 5'd1, 5'd2, OP_OR);
    t_rtype(6'h2A, 5'd7, 5'd2, 5'd1, OP_SLT);
    t_rtype(6'h2A, 5'd8, 5'd1, 5'd2, OP_SLT);
    t_rtype(6'h20, 5'd0, 5'd1, 5'd1, OP_ADD);

    t_store(5'd1, 5'd0, 16'h00D0, 32'h0000_00D0, 32'd7, "R9 load wrote rt from MDR");
    t_store(5'd3, 5'd0, 16'h00D4, 32'h0000_00D4, 32'd4, "R7 add result");
    t_store(5'd4, 5'd10, 16'hFFF8, 32'h0000_00D8, 32'd10, "R7 sub result via negative offset R6");
    t_store(5'd5, 5'd0, 16'h00DC, 32'h0000_00DC, 32'd5, "R7 and result");
    t_store(5'd6, 5'd0, 16'h00E4, 32'h0000_00E4, 32'hFFFF_FFFF, "R7 or result");
    t_store(5'd7, 5'd0, 16'h00E8, 32'h0000_00E8, 32'd1, "R7 signed slt true");
    t_store(5'd8, 5'd0, 16'h00EC, 32'h0000_00EC, 32'd0, "R7 signed slt false");
    t_store(5'd0, 5'd0, 16'h00F0, 32'h0000_00F0, 32'd0, "R10 r0 write ignored");
    t_store(5'd10, 5'd0, 16'h00F4, 32'h0000_00F4, 32'h0000_00E0, "R5 latch B from rt");
    check("R4 stored word in memory", mem[61], 32'h0000_00E0);

    t_beq(5'd1, 5'd1, 16'd2, 1'b1);
    t_beq(5'd1, 5'd2, 16'd5, 1'b0);
    t_jump(26'd40);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule